// File: doc/BRIEF.md
# Eight-Phase Instruction Subcycle Generator

This block produces the timing skeleton for a small 4-bit processor core that runs from a fast system clock. A free-running phase counter shapes two registered, non-overlapping phase strobes, `phi1` and `phi2`. Each strobe stays high for a programmable number of system clocks, and a programmable number of idle clocks separates the two strobes. An eight-stage one-hot ring moves forward once per `phi1` pulse. Its outputs are the eight subcycle enables of an instruction cycle, in the order A1, A2, A3, M1, M2, X1, X2, X3.

While the ring sits in X3, the block drives a `sync` marker. Peripheral devices that keep their own copy of the ring use it to line up with this one. No start command is needed. The ring feedback inserts a fresh token only when the lower seven stages are empty. This means the ring reaches and keeps a legal one-hot state from any starting pattern, including all-zero and multi-hot values, within eight advances. The starting pattern is the `INIT` parameter, which defaults to X3.

Top module: `subcycle_gen`

## Requirements
- R1: While `rst_n` is low, `phi1` and `phi2` are 0, `sub` equals `INIT` (default 8'h80, X3 active) and `sync` is 1.
- R2: `phi1` is high for exactly `PHASE_CLKS` consecutive system clocks (default 8, never fewer than 8). It repeats every `2*(PHASE_CLKS+GAP_CLKS)` clocks and first goes high on the first system clock edge after reset release.
- R3: `phi2` is high for exactly `PHASE_CLKS` consecutive clocks. It starts `GAP_CLKS` clocks after `phi1` falls.
- R4: `phi1` and `phi2` are never high together. Each falling strobe is followed by at least one clock in which both are low.
- R5: With a legal start value, `sub` is one-hot on every clock.
- R6: `sub` changes only on the system clock edge directly after the first clock of a `phi1` pulse, which is one clock after `phi1` rises. It stays unchanged at all other times.
- R7: Each advance moves the active bit one position up, from bit 0 (A1) to bit 7 (X3). From bit 7 it wraps back to bit 0. The bit order is A1, A2, A3, M1, M2, X1, X2, X3.
- R8: `sync` is high exactly when `sub[7]` (X3) is active.
- R9: From any start pattern the ring is one-hot after at most eight advances and stays one-hot. All-zero becomes A1 after one advance, 8'h60 after three, and 8'hFF after eight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phi1 | output | 1 | First phase strobe, registered |
| phi2 | output | 1 | Second phase strobe, registered |
| sub | output | 8 | One-hot subcycle enables, bit 0 = A1 up to bit 7 = X3 |
| sync | output | 1 | High during subcycle X3 |

## Verification
The checker assumes that reset is held for at least one system clock edge and that the ring starts from a one-hot value. The one-hot and rotation properties only start to apply once the checker has seen a one-hot `sub`. This lets instances with a corrupt start pattern run under the same bound checker. The pulse-length property assumes `PHASE_CLKS` is at least eight. The stimulus keeps within these limits by using only the default timing parameters and by driving reset low for several clocks before releasing it on a falling edge. Corrupt start patterns are tried only through extra instances whose `INIT` is illegal.

// File: rtl/subcycle_gen.sv
module subcycle_gen #(
  parameter int          PHASE_CLKS = 8,
  parameter int          GAP_CLKS   = 1,
  parameter logic [7:0]  INIT       = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       phi1,
  output logic       phi2,
  output logic [7:0] sub,
  output logic       sync
);
  localparam int PERIOD = 2 * (PHASE_CLKS + GAP_CLKS);
  localparam int CW     = $clog2(PERIOD);
  localparam int P2_ON  = PHASE_CLKS + GAP_CLKS;
  localparam int P2_OFF = P2_ON + PHASE_CLKS;

  logic [CW-1:0] cnt;
  logic          phi1_d;
  logic [7:0]    ring;

  wire wrap    = (cnt == CW'(PERIOD - 1));
  wire advance = phi1 & ~phi1_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      phi1   <= 1'b0;
      phi2   <= 1'b0;
      phi1_d <= 1'b0;
      ring   <= INIT;
    end else begin
      cnt    <= wrap ? '0 : cnt + 1'b1;
      phi1   <= (cnt < CW'(PHASE_CLKS));
      phi2   <= (cnt >= CW'(P2_ON)) && (cnt < CW'(P2_OFF));
      phi1_d <= phi1;
      if (advance)
        ring <= {ring[6:0], ~|ring[6:0]};
    end
  end

  assign sub  = ring;
  assign sync = ring[7];
endmodule

// File: rtl/subcycle_chk.sv
module subcycle_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phi1,
  input logic       phi2,
  input logic [7:0] sub,
  input logic       sync
);
  logic        p1_d;
  logic        ok;
  logic [15:0] run1, run2, len1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1_d <= 1'b0;
      ok   <= 1'b0;
      run1 <= '0;
      run2 <= '0;
      len1 <= '0;
    end else begin
      p1_d <= phi1;
      if ($onehot(sub)) ok <= 1'b1;
      run1 <= phi1 ? run1 + 16'd1 : 16'd0;
      run2 <= phi2 ? run2 + 16'd1 : 16'd0;
      if (!phi1 && run1 != 16'd0) len1 <= run1;
    end
  end

  wire rise = phi1 && !p1_d;

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(phi1 && phi2));
  a_r4_gap_after_phi1: assert property (@(posedge clk) disable iff (!rst_n) $fell(phi1) |-> !phi2);
  a_r4_gap_after_phi2: assert property (@(posedge clk) disable iff (!rst_n) $fell(phi2) |-> !phi1);
  a_r2_min_width: assert property (@(posedge clk) disable iff (!rst_n) $fell(phi1) |-> run1 >= 16'd8);
  a_r3_equal_width: assert property (@(posedge clk) disable iff (!rst_n) $fell(phi2) |-> run2 == len1);
  a_r8_sync_x3: assert property (@(posedge clk) disable iff (!rst_n) sync == sub[7]);
  a_r9_stays_legal: assert property (@(posedge clk) disable iff (!rst_n) ok |-> $onehot(sub));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n) !rise |=> $stable(sub));
  a_r7_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && $onehot(sub)) |=> sub == {$past(sub[6:0]), $past(sub[7])});
endmodule

bind subcycle_gen subcycle_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2), .sub(sub), .sync(sync)
);

// File: tb/sim_subcycle_gen.sv
module sim_subcycle_gen;
  localparam int PH = 8;
  localparam int G  = 1;
  localparam int P  = 2 * (PH + G);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       p1_0, p2_0, s_0, p1_1, p2_1, s_1, p1_2, p2_2, s_2, p1_3, p2_3, s_3;
  logic [7:0] sub_0, sub_1, sub_2, sub_3;

  subcycle_gen u0 (.clk(clk), .rst_n(rst_n), .phi1(p1_0), .phi2(p2_0), .sub(sub_0), .sync(s_0));
  subcycle_gen #(.INIT(8'h60)) u1 (.clk(clk), .rst_n(rst_n), .phi1(p1_1), .phi2(p2_1), .sub(sub_1), .sync(s_1));
  subcycle_gen #(.INIT(8'hFF)) u2 (.clk(clk), .rst_n(rst_n), .phi1(p1_2), .phi2(p2_2), .sub(sub_2), .sync(s_2));
  subcycle_gen #(.INIT(8'h00)) u3 (.clk(clk), .rst_n(rst_n), .phi1(p1_3), .phi2(p2_3), .sub(sub_3), .sync(s_3));

  int checks = 0;
  int fails  = 0;
  int k      = 0;

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    k++;
  endtask

  function automatic bit m_p1(int n);
    return n >= 1 && ((n - 1) % P) < PH;
  endfunction
  function automatic bit m_p2(int n);
    return n >= 1 && ((n - 1) % P) >= PH + G && ((n - 1) % P) < 2 * PH + G;
  endfunction
  function automatic int m_adv(int n);
    return (n >= 2) ? (n - 2) / P + 1 : 0;
  endfunction
  function automatic logic [7:0] m_sub(int n);
    return 8'h01 << ((m_adv(n) + 7) % 8);
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(p1_0 == 1'b0, "R1 phi1 in reset", p1_0, 0);
    check(p2_0 == 1'b0, "R1 phi2 in reset", p2_0, 0);
    check(sub_0 == 8'h80, "R1 sub in reset", sub_0, 8'h80);
    check(s_0 == 1'b1, "R1 sync in reset", s_0, 1);
    rst_n = 1'b1;
    k = 0;
  endtask

  task automatic t_shape(input int n);
    int e1 = 0, e2 = 0, ov = 0, gap = 0, w1 = 0, w2 = 0;
    bit l1 = 0, l2 = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (p1_0 !== m_p1(k)) e1++;
      if (p2_0 !== m_p2(k)) e2++;
      if (p1_0 && p2_0) ov++;
      if ((l1 && !p1_0 && p2_0) || (l2 && !p2_0 && p1_0)) gap++;
      if (p1_0) w1++;
      if (p2_0) w2++;
      l1 = p1_0;
      l2 = p2_0;
    end
    check(e1 == 0, "R2 phi1 shape mismatches", e1, 0);
    check(w1 == PH * (n / P), "R2 phi1 high count", w1, PH * (n / P));
    check(e2 == 0, "R3 phi2 shape mismatches", e2, 0);
    check(w2 == PH * (n / P), "R3 phi2 high count", w2, PH * (n / P));
    check(ov == 0, "R4 overlapping cycles", ov, 0);
    check(gap == 0, "R4 missing idle clock", gap, 0);
  endtask

  task automatic t_ring(input int n);
    int es = 0, eo = 0, ey = 0, chg = 0, badchg = 0;
    logic [7:0] prev = sub_0;
    for (int i = 0; i < n; i++) begin
      step();
      if (sub_0 !== m_sub(k)) es++;
      if (!$onehot(sub_0)) eo++;
      if (s_0 !== sub_0[7]) ey++;
      if (sub_0 != prev) begin
        chg++;
        if (!(k >= 2 && (k - 2) % P == 0)) badchg++;
      end
      prev = sub_0;
    end
    check(es == 0, "R7 subcycle order mismatches", es, 0);
    check(eo == 0, "R5 non one-hot cycles", eo, 0);
    check(ey == 0, "R8 sync mismatches", ey, 0);
    check(badchg == 0, "R6 changes at wrong edge", badchg, 0);
    check(chg == n / P, "R6 advance count", chg, n / P);
  endtask

  task automatic t_recover(input int n);
    int e0 = 0, e60 = 0, eff = 0;
    for (int i = 0; i < n; i++) begin
      int a;
      step();
      a = m_adv(k);
      if (a >= 1 && sub_3 !== (8'h01 << ((a - 1) % 8))) e0++;
      if (a >= 3 && sub_1 !== (8'h01 << ((a - 3) % 8))) e60++;
      if (a >= 8 && sub_2 !== (8'h01 << ((a - 8) % 8))) eff++;
    end
    check(e0 == 0, "R9 all-zero start", e0, 0);
    check(e60 == 0, "R9 8'h60 start", e60, 0);
    check(eff == 0, "R9 8'hFF start", eff, 0);
  endtask

  initial begin
    t_reset();
    t_shape(3 * P);
    t_recover(12 * P);
    t_ring(20 * P);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule